// File: doc/BRIEF.md
# Windowed Watchdog with Two-Key Service

This block is a supervisory timer that forces a reset of the surrounding system when software stops servicing it correctly. It counts pulses of a time base that is separate from the bus clock. The pulses arrive as a one-cycle strobe that has already been brought into the block's clock domain. To service the timer, software writes the arm key 0x55 and then the fire key 0xAA to the key register. Any other value written there, or a fire key that no arm key came before, causes a reset at once. When window mode is on, a service that completes before the last quarter of the period also causes a reset.

A small configuration register sets the timeout, window mode, freezing while a debugger is active, and clock gating in stop mode. During reset the timeout and window fields are loaded from a nonvolatile configuration byte, so the timer is running before software has done anything. Each watchdog reset sets a sticky flag and records which events caused it. Only the power-on reset clears these, so the cause can still be read after the reset that the block itself requested.

Top module: `wwd_top`

## Requirements
- R1: While `rst_i` or `por_i` is high, the configuration takes the period select from `nv_cfg_i[2:0]` and the window enable from `nv_cfg_i[3]`. The freeze and stop-gate bits are cleared whatever the byte holds. With a nonzero select, the timer counts from reset release with no register write.
- R2: With period select s (configuration bits [2:0]) nonzero, the timer expires 2^(BASE_LOG2+s) time base ticks after its last restart. Only cycles with `tick_i` high advance it. `wd_rst_o` pulses after the edge that takes the final tick, with cause bit 0 (timeout) set.
- R3: On the key register (`wr_sel_i`=1), any value other than 0x55 or 0xAA forces a reset on that same edge with cause bit 2 set. So does 0xAA when no 0x55 has been written since the last fire key, bad key or restart.
- R4: A 0x55 write followed later by a 0xAA write, with only idle cycles or more 0x55 writes between them, is a valid service. It restarts the count at zero and raises no reset.
- R5: With configuration bit 3 set, a service that completes while the count is below three quarters of the period forces a reset with cause bit 1 (window). At or above that point the service is accepted.
- R6: With configuration bit 4 set, the count holds while `dbg_active_i` is high. With bit 4 clear, the count keeps running during debug.
- R7: With configuration bit 5 set, the count holds while `stop_mode_i` is high. With bit 5 clear, the count keeps running in stop mode.
- R8: Every watchdog reset sets `wd_flag_o` and loads `wd_cause_o` with the events of that cycle. Both keep their values through `rst_i` and are cleared only by `por_i`.
- R9: With period select 0, the timer is disabled. It never expires, and writes to the key register of any value have no effect.
- R10: A configuration write (`wr_sel_i`=0) loads `wr_data_i[5:0]` and restarts the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset, synchronous, active high; also clears flag and cause |
| rst_i | input | 1 | System reset, synchronous, active high |
| tick_i | input | 1 | One-cycle strobe from the independent time base |
| dbg_active_i | input | 1 | A debugger holds the system |
| stop_mode_i | input | 1 | The system is in stop mode |
| nv_cfg_i | input | 8 | Nonvolatile configuration byte sampled during reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 configuration, 1 key |
| wr_data_i | input | 8 | Write data |
| wd_rst_o | output | 1 | One-cycle reset request |
| wd_flag_o | output | 1 | Sticky watchdog-reset flag |
| wd_cause_o | output | 3 | Cause of the last watchdog reset: bit 0 timeout, bit 1 window, bit 2 bad key |

## Verification
Each result is due one clock edge after the stimulus that causes it. A key or configuration write shows its effect on `wd_rst_o` and `wd_cause_o` right after the edge that samples the write. A timeout shows just after the edge that takes the final tick. The bench drives inputs and samples outputs on the falling edge, so each check reads the value from the edge just taken. Timeout checks count the ticks the bench drove since the restart edge and compare that count with the period, even when ticks are spaced apart.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int SEL_W = 3;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef struct packed {
    logic             stop_gate;
    logic             dbg_freeze;
    logic             win_en;
    logic [SEL_W-1:0] sel;
  } wwd_cfg_t;

  typedef struct packed {
    logic bad_key;
    logic win_err;
    logic expired;
  } wwd_cause_t;
endpackage

// File: rtl/wwd_cfg.sv
module wwd_cfg
  import wwd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_i,
  input  logic     wr_i,
  input  logic [7:0] wdat_i,
  input  logic [7:0] nv_i,
  output wwd_cfg_t cfg_o
);
  localparam int CFG_W = $bits(wwd_cfg_t);

  always_ff @(posedge clk) begin
    if (rst_i) begin
      cfg_o.stop_gate  <= 1'b0;
      cfg_o.dbg_freeze <= 1'b0;
      cfg_o.win_en     <= nv_i[SEL_W];
      cfg_o.sel        <= nv_i[SEL_W-1:0];
    end else if (wr_i) begin
      cfg_o <= wwd_cfg_t'(wdat_i[CFG_W-1:0]);
    end
  end

  AST_PRELOAD_SAFE: assert property (@(posedge clk) disable iff (rst_i)
    $past(rst_i) |-> (!cfg_o.dbg_freeze && !cfg_o.stop_gate)); // R1
endmodule

// File: rtl/wwd_count.sv
module wwd_count
  import wwd_pkg::*;
#(
  parameter int BASE_LOG2 = 2
) (
  input  logic     clk,
  input  logic     rst_i,
  input  wwd_cfg_t cfg_i,
  input  logic     tick_i,
  input  logic     dbg_i,
  input  logic     stop_i,
  input  logic     restart_i,
  output logic     enabled_o,
  output logic     expire_o,
  output logic     in_win_o
);
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   period;
  logic [CNT_W:0]   last;
  logic [CNT_W:0]   win_lo;
  logic             run;
  int               shamt;

  always_comb begin
    shamt     = BASE_LOG2 + int'(cfg_i.sel);
    period    = {{CNT_W{1'b0}}, 1'b1} << shamt;
    last      = period - 1'b1;
    win_lo    = period - (period >> 2);
    enabled_o = (cfg_i.sel != '0);
    run       = enabled_o && !(dbg_i && cfg_i.dbg_freeze) && !(stop_i && cfg_i.stop_gate);
    expire_o  = run && tick_i && ({1'b0, cnt} == last);
    in_win_o  = ({1'b0, cnt} >= win_lo);
  end

  always_ff @(posedge clk) begin
    if (rst_i || restart_i || !enabled_o) begin
      cnt <= '0;
    end else if (run && tick_i) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst_i)
    enabled_o |-> ({1'b0, cnt} <= last)); // R2
  AST_HOLD_PAUSED: assert property (@(posedge clk) disable iff (rst_i)
    (enabled_o && !run && !restart_i) |=> $stable(cnt)); // R6
endmodule

// File: rtl/wwd_key.sv
module wwd_key
  import wwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_i,
  input  logic       kwr_i,
  input  logic [7:0] kdat_i,
  input  logic       clr_i,
  output logic       svc_o,
  output logic       bad_o
);
  logic armed;

  always_comb begin
    svc_o = kwr_i && (kdat_i == KEY_FIRE) && armed;
    bad_o = kwr_i && !svc_o && (kdat_i != KEY_ARM);
  end

  always_ff @(posedge clk) begin
    if (rst_i || clr_i) begin
      armed <= 1'b0;
    end else if (kwr_i) begin
      armed <= (kdat_i == KEY_ARM);
    end
  end

  AST_SVC_DISARMS: assert property (@(posedge clk) disable iff (rst_i)
    svc_o |=> !armed); // R4
  AST_BAD_DISARMS: assert property (@(posedge clk) disable iff (rst_i)
    bad_o |=> !armed); // R3
endmodule

// File: rtl/wwd_top.sv
module wwd_top
  import wwd_pkg::*;
#(
  parameter int BASE_LOG2 = 2
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       rst_i,
  input  logic       tick_i,
  input  logic       dbg_active_i,
  input  logic       stop_mode_i,
  input  logic [7:0] nv_cfg_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic       wd_rst_o,
  output logic       wd_flag_o,
  output logic [2:0] wd_cause_o
);
  logic       rst_all;
  wwd_cfg_t   cfg;
  logic       cfg_wr, key_wr;
  logic       enabled, expire, in_win;
  logic       svc, bad, win_err, good_svc;
  logic       restart;
  wwd_cause_t evt;
  wwd_cause_t cause_q;

  assign rst_all = por_i || rst_i;
  assign cfg_wr  = wr_en_i && !wr_sel_i;
  assign key_wr  = wr_en_i && wr_sel_i && enabled;

  wwd_cfg u_cfg (
    .clk    (clk),
    .rst_i  (rst_all),
    .wr_i   (cfg_wr),
    .wdat_i (wr_data_i),
    .nv_i   (nv_cfg_i),
    .cfg_o  (cfg)
  );

  wwd_count #(.BASE_LOG2(BASE_LOG2)) u_count (
    .clk       (clk),
    .rst_i     (rst_all),
    .cfg_i     (cfg),
    .tick_i    (tick_i),
    .dbg_i     (dbg_active_i),
    .stop_i    (stop_mode_i),
    .restart_i (restart),
    .enabled_o (enabled),
    .expire_o  (expire),
    .in_win_o  (in_win)
  );

  wwd_key u_key (
    .clk    (clk),
    .rst_i  (rst_all),
    .kwr_i  (key_wr),
    .kdat_i (wr_data_i),
    .clr_i  (restart),
    .svc_o  (svc),
    .bad_o  (bad)
  );

  always_comb begin
    win_err      = svc && cfg.win_en && !in_win;
    good_svc     = svc && !win_err;
    evt.expired  = expire;
    evt.win_err  = win_err;
    evt.bad_key  = bad;
    restart      = cfg_wr || good_svc || (evt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst_all) wd_rst_o <= 1'b0;
    else         wd_rst_o <= (evt != '0);
  end

  always_ff @(posedge clk) begin
    if (por_i) begin
      wd_flag_o <= 1'b0;
      cause_q   <= '0;
    end else if (!rst_i && (evt != '0)) begin
      wd_flag_o <= 1'b1;
      cause_q   <= evt;
    end
  end

  assign wd_cause_o = cause_q;

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst_all)
    wd_rst_o |-> wd_flag_o); // R8
  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst_all)
    wd_rst_o |-> (wd_cause_o != 3'b000)); // R8
  AST_EXPIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst_all)
    (wd_rst_o && wd_cause_o == 3'b001) |-> $past(tick_i)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (por_i)
    $past(wd_flag_o) && !$past(por_i) |-> wd_flag_o); // R8
endmodule

// File: tb/wwd_top_bench.sv
module wwd_top_bench;
  localparam int BASE_LOG2 = 2;

  logic       clk = 1'b0;
  logic       por_i = 1'b0, rst_i = 1'b0, tick_i = 1'b0;
  logic       dbg_active_i = 1'b0, stop_mode_i = 1'b0;
  logic [7:0] nv_cfg_i = 8'h00;
  logic       wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       wd_rst_o, wd_flag_o;
  logic [2:0] wd_cause_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wwd_top #(.BASE_LOG2(BASE_LOG2)) u_wwd_top (
    .clk(clk), .por_i(por_i), .rst_i(rst_i), .tick_i(tick_i),
    .dbg_active_i(dbg_active_i), .stop_mode_i(stop_mode_i),
    .nv_cfg_i(nv_cfg_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .wd_rst_o(wd_rst_o), .wd_flag_o(wd_flag_o),
    .wd_cause_o(wd_cause_o)
  );

  function automatic int period(input int s);
    return 1 << (BASE_LOG2 + s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit full);
    @(negedge clk);
    rst_i = 1'b1; por_i = full; tick_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_i = 1'b0; por_i = 1'b0;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    tick_i = 1'b0;
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic run_until(input int limit, input int div, output int tk, output bit hit);
    tk = 0; hit = 1'b0;
    for (int i = 0; i < limit; i++) begin
      tick_i = ((i % div) == div - 1);
      if (tick_i) tk++;
      @(negedge clk);
      if (wd_rst_o) begin hit = 1'b1; break; end
    end
    tick_i = 1'b0;
  endtask

  task automatic expect_expiry(input int p, input int div, input string req);
    int tk; bit hit;
    run_until(p * div + 50, div, tk, hit);
    chk(hit && tk == p, req, tk, p);
    chk(wd_cause_o == 3'b001, req, wd_cause_o, 1);
  endtask

  task automatic expect_quiet(input int cycles, input string req);
    int tk; bit hit;
    run_until(cycles, 1, tk, hit);
    chk(!hit, req, hit, 0);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    // R8 reset state
    chk(wd_rst_o == 1'b0, "R8 reset pulse", wd_rst_o, 0);
    chk(wd_flag_o == 1'b0, "R8 reset flag", wd_flag_o, 0);
    chk(wd_cause_o == 3'b000, "R8 reset cause", wd_cause_o, 0);

    // R9 disabled: no expiry, key writes ignored
    expect_quiet(600, "R9 no expiry");
    wr(1'b1, 8'h13);
    chk(wd_rst_o == 1'b0, "R9 key ignored", wd_rst_o, 0);
    wr(1'b1, 8'hAA);
    chk(wd_rst_o == 1'b0, "R9 fire ignored", wd_rst_o, 0);
    chk(wd_flag_o == 1'b0, "R9 flag untouched", wd_flag_o, 0);

    // R2 sweep of every period select
    for (int s = 1; s < 8; s++) begin
      wr(1'b0, 8'(s));
      expect_expiry(period(s), 1, "R2 sweep");
    end
    wr(1'b0, 8'h02);
    expect_expiry(period(2), 3, "R2 sparse ticks");

    // R10 configuration write restarts the count
    wr(1'b0, 8'h02);
    expect_quiet(10, "R10 before rewrite");
    wr(1'b0, 8'h02);
    expect_expiry(period(2), 1, "R10 restart");

    // R3 every key value; only 0x55 is accepted alone
    wr(1'b0, 8'h03);
    for (int v = 0; v < 256; v++) begin
      wr(1'b1, 8'(v));
      if (v == 8'h55) chk(wd_rst_o == 1'b0, "R3 arm key", wd_rst_o, 0);
      else begin
        chk(wd_rst_o == 1'b1, "R3 bad key pulse", wd_rst_o, 1);
        chk(wd_cause_o == 3'b100, "R3 bad key cause", wd_cause_o, 4);
      end
    end

    // R4 valid service restarts the count
    wr(1'b0, 8'h02);
    expect_quiet(10, "R4 pre-service");
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hAA);
    chk(wd_rst_o == 1'b0, "R4 service accepted", wd_rst_o, 0);
    expect_expiry(period(2), 1, "R4 restart");
    expect_quiet(5, "R4 second run");
    wr(1'b1, 8'h55);
    wr(1'b1, 8'h55);
    @(negedge clk);
    wr(1'b1, 8'hAA);
    chk(wd_rst_o == 1'b0, "R4 repeated arm", wd_rst_o, 0);
    expect_expiry(period(2), 1, "R4 repeated arm restart");

    // R5 window sweep for period 8 (window opens at 6)
    for (int k = 0; k < 8; k++) begin
      wr(1'b0, 8'h09);
      if (k > 0) expect_quiet(k, "R5 advance");
      wr(1'b1, 8'h55);
      wr(1'b1, 8'hAA);
      chk(wd_rst_o == (k < 6), "R5 window sweep", wd_rst_o, (k < 6));
      if (k < 6) chk(wd_cause_o == 3'b010, "R5 window cause", wd_cause_o, 2);
    end
    for (int k = 23; k < 25; k++) begin
      wr(1'b0, 8'h0B);
      expect_quiet(k, "R5 advance");
      wr(1'b1, 8'h55);
      wr(1'b1, 8'hAA);
      chk(wd_rst_o == (k < 24), "R5 window edge", wd_rst_o, (k < 24));
    end
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hAA);
    chk(wd_rst_o == 1'b0, "R5 window off early service", wd_rst_o, 0);

    // R6 debug freeze
    wr(1'b0, 8'h11);
    dbg_active_i = 1'b1;
    expect_quiet(100, "R6 frozen");
    dbg_active_i = 1'b0;
    expect_expiry(period(1), 1, "R6 resume");
    wr(1'b0, 8'h11);
    expect_quiet(5, "R6 partial");
    dbg_active_i = 1'b1;
    expect_quiet(50, "R6 partial frozen");
    dbg_active_i = 1'b0;
    expect_expiry(period(1) - 5, 1, "R6 partial resume");
    wr(1'b0, 8'h01);
    dbg_active_i = 1'b1;
    expect_expiry(period(1), 1, "R6 runs in debug");
    dbg_active_i = 1'b0;

    // R7 stop gating
    wr(1'b0, 8'h21);
    stop_mode_i = 1'b1;
    expect_quiet(100, "R7 gated");
    stop_mode_i = 1'b0;
    expect_expiry(period(1), 1, "R7 resume");
    wr(1'b0, 8'h01);
    stop_mode_i = 1'b1;
    expect_expiry(period(1), 1, "R7 runs in stop");
    stop_mode_i = 1'b0;

    // R1 preload with system reset; R8 flag survives it
    nv_cfg_i = 8'h3A;
    do_reset(1'b0);
    chk(wd_flag_o == 1'b1, "R8 flag kept", wd_flag_o, 1);
    chk(wd_cause_o == 3'b001, "R8 cause kept", wd_cause_o, 1);
    dbg_active_i = 1'b1;
    stop_mode_i = 1'b1;
    expect_expiry(period(2), 1, "R1 preload period");
    dbg_active_i = 1'b0;
    stop_mode_i = 1'b0;
    do_reset(1'b0);
    expect_quiet(3, "R1 advance");
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hAA);
    chk(wd_rst_o == 1'b1, "R1 preload window", wd_rst_o, 1);
    chk(wd_cause_o == 3'b010, "R1 preload window cause", wd_cause_o, 2);

    // R8 power-on reset clears flag and cause
    nv_cfg_i = 8'h00;
    do_reset(1'b1);
    chk(wd_flag_o == 1'b0, "R8 por flag", wd_flag_o, 0);
    chk(wd_cause_o == 3'b000, "R8 por cause", wd_cause_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule